// File: doc/BRIEF.md
# Packet Fetch and Lock-Step Dispatch Front End

This block is the instruction front end of an eight-unit very-long-instruction-word core. It generates a 32-bit program address and sends it to program memory. It waits out a fixed two-stage memory access and captures the 256-bit fetch packet that comes back. It then dispatches and decodes that packet as eight 32-bit slots, one for each functional unit. Every packet moves through eleven named stages in lock step: address generate (AG), address send (PS), access wait (PW), packet receive (PR), dispatch (DP), decode (DC), and execute stages E1 to E5. A new packet can enter every cycle.

A small controller in the address-generate stage owns the program counter. It has three states. In IDLE, after reset, no address is valid and nothing is fetched. In RUN, the program counter steps by 32 bytes on every cycle that is not stalled. In HOLD, a stall freezes the program counter. The transitions are:
- IDLE to RUN on a redirect while there is no stall.
- IDLE to HOLD on a redirect during a stall.
- RUN to HOLD when the stall rises.
- HOLD to RUN when the stall falls.

A redirect in any state loads the target into the program counter, rounded down to a 32-byte boundary. It also discards every packet still in PS, PW or PR. Packets already in DP or later are kept and drain normally. A global stall freezes every stage register.

Top module: `vliw_frontend`

## Requirements
- R1: Synchronous active-high reset clears every stage valid bit, so `pm_req_valid`, `issue_valid` and `ex_valid` read zero. Without a redirect the block stays idle and raises no request.
- R2: A redirect loads `redir_addr` with its low five bits cleared. After the next unstalled edge, `pm_req_valid` is 1 and `pm_req_addr` holds that aligned address.
- R3: Program memory must present the packet for the address on `pm_req_addr` on `pm_rsp_data` after two unstalled edges, and hold it while stalled. Under that contract, the packet of a redirect target reaches the issue ports after the fifth unstalled edge that follows the edge that took the redirect.
- R4: While the block runs unstalled and without redirects, a new packet issues every cycle. Each packet's `issue_addr` is 32 above the previous one.
- R5: Bits 32*i+31:32*i of the issued packet equal the same bits of the memory response. Slot i feeds unit i in the order L1, S1, M1, D1, D2, M2, S2, L2. All eight `issue_valid` bits are set together or cleared together.
- R6: While `stall` is high, every stage holds its contents: the request port, the issue ports and the execute stages do not change. When the stall ends, the stream resumes with no packet lost or repeated.
- R7: A redirect without a stall discards the packets in PS, PW and PR. The packet in DP still issues on the following cycle. Four empty issue cycles then come before the target packet.
- R8: A redirect during a stall is taken at once, and PS, PW and PR become empty. DP, DC and the execute stages stay frozen until the stall ends.
- R9: An issued packet advances through E1 to E5 one stage per unstalled edge. `ex_valid[k]` marks stage E(k+1). `ex_last_addr` shows the address of the packet in E5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Global freeze of all stage registers |
| redir_valid | input | 1 | Load a new fetch address this cycle |
| redir_addr | input | 32 | Redirect target byte address |
| pm_req_valid | output | 1 | Program-memory request is valid (PS stage) |
| pm_req_addr | output | 32 | Program-memory packet address (PS stage) |
| pm_rsp_data | input | 256 | Fetch packet returned for the PR stage |
| issue_valid | output | 8 | Per-unit issue valid, unit order L1,S1,M1,D1,D2,M2,S2,L2 |
| issue_insn | output | 256 | Eight 32-bit instruction slots, slot i for unit i |
| issue_addr | output | 32 | Address of the packet at the issue ports (DC stage) |
| ex_valid | output | 5 | Valid bits of execute stages E1..E5 |
| ex_last_addr | output | 32 | Address of the packet in E5 |

## Verification
Stall and redirect can arrive in the same cycle, and their effects overlap. The redirect must still reset the program counter and empty the three fetch stages, while the stall holds everything from dispatch onward. The bench raises both together while a steady stream is running and keeps the stall for two more cycles. It checks that the issue ports stay frozen throughout and that the request port goes idle. After the stall ends, it expects exactly one older packet (the one held in DP), then three empty cycles, then the target packet on the fifth unstalled edge.

// File: rtl/vfe_pkg.sv
package vfe_pkg;
    localparam int ADDR_W    = 32;
    localparam int INSN_W    = 32;
    localparam int SLOTS     = 8;
    localparam int EX_STAGES = 5;
    localparam int PKT_W     = INSN_W * SLOTS;
    localparam int PKT_BYTES = PKT_W / 8;

    typedef enum logic [1:0] {
        FE_IDLE = 2'd0,
        FE_RUN  = 2'd1,
        FE_HOLD = 2'd2
    } fe_state_t;
endpackage

// File: rtl/vfe_ctrl.sv
module vfe_ctrl
    import vfe_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int BYTES = PKT_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stall,
    input  logic          redir_valid,
    input  logic [AW-1:0] redir_addr,
    output logic          ag_valid,
    output logic [AW-1:0] ag_addr
);
    localparam logic [AW-1:0] STEP  = AW'(BYTES);
    localparam logic [AW-1:0] ALIGN = ~(AW'(BYTES) - AW'(1));

    fe_state_t     state, state_nxt;
    logic [AW-1:0] pc;
    logic          pc_step;

    always_ff @(posedge clk) begin
        if (rst) state <= FE_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            FE_IDLE: if (redir_valid) state_nxt = stall ? FE_HOLD : FE_RUN;
            FE_RUN:  if (stall)       state_nxt = FE_HOLD;
            FE_HOLD: if (!stall)      state_nxt = FE_RUN;
            default:                  state_nxt = FE_IDLE;
        endcase
    end

    always_comb begin
        ag_valid = 1'b0;
        pc_step  = 1'b0;
        unique case (state)
            FE_IDLE: begin ag_valid = 1'b0; pc_step = 1'b0;    end
            FE_RUN:  begin ag_valid = 1'b1; pc_step = !stall;  end
            FE_HOLD: begin ag_valid = 1'b1; pc_step = !stall;  end
            default: begin ag_valid = 1'b0; pc_step = 1'b0;    end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)              pc <= '0;
        else if (redir_valid) pc <= redir_addr & ALIGN;
        else if (pc_step)     pc <= pc + STEP;
    end

    assign ag_addr = pc;

    AST_REDIR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (ag_valid && ((ag_addr & ~ALIGN) == '0))); // R2
    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (stall && !redir_valid) |=> $stable(ag_addr)); // R6
endmodule

// File: rtl/vfe_fetch.sv
module vfe_fetch
    import vfe_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          squash,
    input  logic          ag_valid,
    input  logic [AW-1:0] ag_addr,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic          pr_valid,
    output logic [AW-1:0] pr_addr
);
    localparam int NST = 3;

    logic [NST-1:0] fv;
    logic [AW-1:0]  fa [NST];

    always_ff @(posedge clk) begin
        if (rst) begin
            fv <= '0;
        end else begin
            if (adv) begin
                fa[0] <= ag_addr;
                for (int k = 1; k < NST; k++) fa[k] <= fa[k-1];
            end
            if (squash)   fv <= '0;
            else if (adv) fv <= {fv[NST-2:0], ag_valid};
        end
    end

    assign req_valid = fv[0];
    assign req_addr  = fa[0];
    assign pr_valid  = fv[NST-1];
    assign pr_addr   = fa[NST-1];

    AST_SQUASH_FETCH: assert property (@(posedge clk) disable iff (rst)
        squash |=> (!req_valid && !pr_valid)); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!adv && !squash) |=> ($stable(req_valid) && $stable(req_addr))); // R6
endmodule

// File: rtl/vfe_issue.sv
module vfe_issue
    import vfe_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int IW  = INSN_W,
    parameter int NS  = SLOTS,
    parameter int NEX = EX_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             squash,
    input  logic             pr_valid,
    input  logic [AW-1:0]    pr_addr,
    input  logic [IW*NS-1:0] pkt_in,
    output logic [NS-1:0]    issue_valid,
    output logic [IW*NS-1:0] issue_insn,
    output logic [AW-1:0]    issue_addr,
    output logic [NEX-1:0]   ex_valid,
    output logic [AW-1:0]    ex_last_addr
);
    localparam int PW = IW * NS;
    localparam logic [AW-1:0] STEP = AW'(PW / 8);

    logic          dp_valid, dc_valid;
    logic [AW-1:0] dp_addr, dc_addr;
    logic [PW-1:0] dp_pkt, dc_pkt;
    logic [NEX-1:0] ev;
    logic [AW-1:0]  ea [NEX];

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_valid <= 1'b0;
            dc_valid <= 1'b0;
            ev       <= '0;
        end else if (adv) begin
            dp_valid <= pr_valid && !squash;
            dc_valid <= dp_valid;
            ev       <= {ev[NEX-2:0], dc_valid};
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            dp_addr <= pr_addr;
            dp_pkt  <= pkt_in;
            dc_addr <= dp_addr;
            dc_pkt  <= dp_pkt;
            ea[0]   <= dc_addr;
            for (int k = 1; k < NEX; k++) ea[k] <= ea[k-1];
        end
    end

    // slot i of the decoded packet feeds functional unit i (L1,S1,M1,D1,D2,M2,S2,L2)
    for (genvar i = 0; i < NS; i++) begin : g_slot
        assign issue_insn[IW*i +: IW] = dc_pkt[IW*i +: IW];
        assign issue_valid[i]         = dc_valid;
    end

    assign issue_addr   = dc_addr;
    assign ex_valid     = ev;
    assign ex_last_addr = ea[NEX-1];

    AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(issue_valid) && $stable(issue_insn) && $stable(ex_valid))); // R6
    AST_PKT_SEQ: assert property (@(posedge clk) disable iff (rst)
        (adv && dp_valid && dc_valid) |=> (issue_addr == $past(issue_addr) + STEP)); // R4
    AST_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
        (issue_valid == '0) || (issue_valid == '1)); // R5
endmodule

// File: rtl/vliw_frontend.sv
module vliw_frontend
    import vfe_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int IW  = INSN_W,
    parameter int NS  = SLOTS,
    parameter int NEX = EX_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             redir_valid,
    input  logic [AW-1:0]    redir_addr,
    output logic             pm_req_valid,
    output logic [AW-1:0]    pm_req_addr,
    input  logic [IW*NS-1:0] pm_rsp_data,
    output logic [NS-1:0]    issue_valid,
    output logic [IW*NS-1:0] issue_insn,
    output logic [AW-1:0]    issue_addr,
    output logic [NEX-1:0]   ex_valid,
    output logic [AW-1:0]    ex_last_addr
);
    localparam int BYTES = IW * NS / 8;

    logic          adv;
    logic          ag_valid, pr_valid;
    logic [AW-1:0] ag_addr, pr_addr;

    assign adv = !stall;

    vfe_ctrl #(.AW(AW), .BYTES(BYTES)) u_ctrl (
        .clk(clk), .rst(rst), .stall(stall),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .ag_valid(ag_valid), .ag_addr(ag_addr)
    );

    vfe_fetch #(.AW(AW)) u_fetch (
        .clk(clk), .rst(rst), .adv(adv), .squash(redir_valid),
        .ag_valid(ag_valid), .ag_addr(ag_addr),
        .req_valid(pm_req_valid), .req_addr(pm_req_addr),
        .pr_valid(pr_valid), .pr_addr(pr_addr)
    );

    vfe_issue #(.AW(AW), .IW(IW), .NS(NS), .NEX(NEX)) u_issue (
        .clk(clk), .rst(rst), .adv(adv), .squash(redir_valid),
        .pr_valid(pr_valid), .pr_addr(pr_addr), .pkt_in(pm_rsp_data),
        .issue_valid(issue_valid), .issue_insn(issue_insn),
        .issue_addr(issue_addr), .ex_valid(ex_valid),
        .ex_last_addr(ex_last_addr)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!pm_req_valid && (issue_valid == '0) && (ex_valid == '0))); // R1
endmodule

// File: tb/vliw_frontend_test.sv
module vliw_frontend_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         stall = 1'b0;
    logic         redir_valid = 1'b0;
    logic [31:0]  redir_addr = '0;
    logic         pm_req_valid;
    logic [31:0]  pm_req_addr;
    logic [255:0] pm_rsp_data;
    logic [7:0]   issue_valid;
    logic [255:0] issue_insn;
    logic [31:0]  issue_addr;
    logic [4:0]   ex_valid;
    logic [31:0]  ex_last_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vliw_frontend uut (
        .clk(clk), .rst(rst), .stall(stall),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .pm_req_valid(pm_req_valid), .pm_req_addr(pm_req_addr),
        .pm_rsp_data(pm_rsp_data),
        .issue_valid(issue_valid), .issue_insn(issue_insn),
        .issue_addr(issue_addr), .ex_valid(ex_valid),
        .ex_last_addr(ex_last_addr)
    );

    // program memory model: two unstalled edges of access, held during a stall
    logic [31:0] mem_a1 = '0, mem_a2 = '0;
    always @(posedge clk) begin
        if (!stall) begin
            mem_a1 <= pm_req_addr;
            mem_a2 <= mem_a1;
        end
    end
    always_comb begin
        for (int i = 0; i < 8; i++) pm_rsp_data[32*i +: 32] = mem_a2 + 32'(4*i);
    end

    function automatic logic [255:0] pkt_of(input logic [31:0] a);
        logic [255:0] p;
        for (int i = 0; i < 8; i++) p[32*i +: 32] = a + 32'(4*i);
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_issue(input string req, input logic [31:0] a);
        chk(issue_valid == 8'hFF, req, 256'(issue_valid), 256'hFF);
        chk(issue_addr == a, req, 256'(issue_addr), 256'(a));
        chk(issue_insn == pkt_of(a), req, issue_insn, pkt_of(a));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        chk(pm_req_valid == 1'b0, "R1 req", 256'(pm_req_valid), 0);
        chk(issue_valid == '0, "R1 issue", 256'(issue_valid), 0);
        chk(ex_valid == '0, "R1 ex", 256'(ex_valid), 0);
        for (int k = 0; k < 4; k++) tick();
        chk(pm_req_valid == 1'b0, "R1 idle without redirect", 256'(pm_req_valid), 0);
    endtask

    task automatic t_start();
        redir_valid = 1'b1; redir_addr = 32'h0000_1014;
        tick();
        redir_valid = 1'b0;
        tick();
        chk(pm_req_valid && pm_req_addr == 32'h1000, "R2 aligned request",
            256'(pm_req_addr), 256'h1000);
        for (int k = 2; k <= 4; k++) begin
            tick();
            chk(issue_valid == '0, "R3 latency early", 256'(issue_valid), 0);
        end
        tick();
        chk_issue("R3 R5 first packet", 32'h1000);
        for (int k = 1; k <= 3; k++) begin
            tick();
            chk_issue("R4 back-to-back", 32'h1000 + 32'(32*k));
        end
    endtask

    task automatic t_stall();
        logic [31:0] a0;
        logic [4:0]  ev0;
        logic [31:0] r0;
        a0 = issue_addr; ev0 = ex_valid; r0 = pm_req_addr;
        stall = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk_issue("R6 frozen issue", a0);
            chk(ex_valid == ev0, "R6 frozen ex", 256'(ex_valid), 256'(ev0));
            chk(pm_req_addr == r0, "R6 frozen request", 256'(pm_req_addr), 256'(r0));
        end
        stall = 1'b0;
        tick();
        chk_issue("R6 resume no loss", a0 + 32'd32);
        tick();
        chk_issue("R6 resume no dup", a0 + 32'd64);
    endtask

    task automatic t_redirect();
        logic [31:0] a0;
        a0 = issue_addr;
        redir_valid = 1'b1; redir_addr = 32'h0000_8000;
        tick();
        redir_valid = 1'b0;
        chk_issue("R7 dispatch packet survives", a0 + 32'd32);
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk(issue_valid == '0, "R7 squashed fetch stages", 256'(issue_valid), 0);
        end
        tick();
        chk_issue("R7 R3 target packet", 32'h8000);
        for (int k = 0; k < 5; k++) tick();
        chk(ex_valid == 5'h1F, "R9 execute stages full", 256'(ex_valid), 256'h1F);
        chk(ex_last_addr == 32'h8000, "R9 E5 address", 256'(ex_last_addr), 256'h8000);
    endtask

    task automatic t_stall_redirect();
        logic [31:0] a0;
        a0 = issue_addr;
        stall = 1'b1; redir_valid = 1'b1; redir_addr = 32'h0000_4000;
        tick();
        redir_valid = 1'b0;
        chk_issue("R8 issue frozen on redirect", a0);
        chk(pm_req_valid == 1'b0, "R8 fetch emptied", 256'(pm_req_valid), 0);
        for (int k = 0; k < 2; k++) begin
            tick();
            chk_issue("R8 still frozen", a0);
        end
        stall = 1'b0;
        tick();
        chk_issue("R8 dispatch packet drains", a0 + 32'd32);
        chk(pm_req_valid && pm_req_addr == 32'h4000, "R8 R2 target request",
            256'(pm_req_addr), 256'h4000);
        for (int k = 2; k <= 4; k++) begin
            tick();
            chk(issue_valid == '0, "R8 bubble", 256'(issue_valid), 0);
        end
        tick();
        chk_issue("R8 target after fifth unstalled edge", 32'h4000);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick();
        t_reset();
        t_start();
        t_stall();
        t_redirect();
        t_stall_redirect();
        tick();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule